// File: doc/BRIEF.md
# Trace Unit Programming Sequencer

This block reconfigures an on-chip trace unit through that unit's debug register port. The block is an APB master. It follows a fixed, handshake-ordered recipe. First it switches the unit's main enable bit off. It then reads the status register until the unit reports that it is idle. Next it writes every entry of a configuration table. After that it switches the enable bit back on. Finally it reads the status register until the unit reports that it is running again. Because every configuration write lands while the unit is idle, all the new settings take effect together when the unit is enabled again. The host processor does not have to be halted for any of this.

A client pulses `start`, holds the table stable while `busy` is high, and waits for either a one-cycle `done` pulse or a one-cycle `fail` pulse with a cause code. The table is supplied on ports as flattened address and data vectors, together with an entry count. The following are parameters: the address of the enable register, the address of the status register, the bit positions of the enable and idle bits, the table depth and the polling limit.

Top module: `trace_seq_top`

## Requirements
- R1: A synchronous active-high `rst` puts the block in its rest state. In the cycle after a reset edge, `psel`, `penable`, `busy`, `done` and `fail` are all 0.
- R2: The first bus transfer after an accepted `start` is a write to address `EN_ADDR` with all data bits 0. This write clears the unit's enable bit.
- R3: After the disabling write, the block reads `STAT_ADDR` repeatedly until bit `IDLE_BIT` of the read data is 1. No configuration write occurs before that read.
- R4: Once idle, the block writes table entries 0 to n-1 in ascending index order. Entry i is address `cfg_addr[i*ADDR_W +: ADDR_W]` with data `cfg_data[i*DATA_W +: DATA_W]`. The value n is `cfg_count` captured at start and limited to `ENTRIES`. If n is 0, no configuration write is made.
- R5: After the last configuration write, the block writes `EN_ADDR` with only bit `EN_BIT` set.
- R6: After enabling, the block reads `STAT_ADDR` until bit `IDLE_BIT` reads 0. It then pulses `done` high for exactly one cycle. In that same cycle `busy` is 0, and no further transfer follows.
- R7: Every transfer has one setup cycle (`psel`=1, `penable`=0) followed by access cycles (`psel`=1, `penable`=1). The access cycles last until `pready` is 1. Address, direction and write data stay stable throughout.
- R8: If `pslverr` is 1 when a transfer completes, the sequence stops at once. `fail` then pulses for one cycle with `fail_cause` = 1, and no further transfer is issued.
- R9: If a polling loop reaches `MAX_POLLS` reads without seeing the expected idle value, the block stops with a `fail` pulse and `fail_cause` = 2. If the enable write has already happened, the block first writes `EN_ADDR` with data 0, so the unit is left disabled.
- R10: `busy` rises in the cycle after `start` is taken while the block is at rest. A `start` that arrives while `busy` is 1 is ignored and does not change the transfer sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to run the sequence |
| cfg_count | input | CNT_W | Number of table entries to write |
| cfg_addr | input | ENTRIES*ADDR_W | Flattened table of register addresses |
| cfg_data | input | ENTRIES*DATA_W | Flattened table of register values |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| fail | output | 1 | One-cycle pulse on abort |
| fail_cause | output | 2 | Abort reason when `fail` is 1: 1 slave error, 2 timeout |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (access phase) |
| pwrite | output | 1 | APB direction, 1 = write |
| paddr | output | ADDR_W | APB address |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data |
| pready | input | 1 | APB ready from slave |
| pslverr | input | 1 | APB slave error |

## Verification
A behavioural trace-unit model sits behind the bus. It can be set to delay its status change by a chosen number of reads, to add wait states, to never go idle, to never leave idle, or to flag an error on one address.

Runs with several table sizes separate correct ordering from skipped or extra writes:
- a short table;
- a full table;
- an empty table;
- a count above the depth, which must be limited to the depth.

Runs with different status delays separate waiting for the idle bit from proceeding early. The model returns complementary patterns in the bits around the idle bit, so a wrong bit position is also caught.

The stuck-status modes and the error address show the two abort paths apart. They also show the disabling write that only the late timeout adds. Extra `start` pulses during a run show that a request made while busy leaves the transfer sequence unchanged.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [2:0] {
        SQ_REST,
        SQ_DISABLE,
        SQ_WAIT_IDLE,
        SQ_PROGRAM,
        SQ_ENABLE,
        SQ_WAIT_RUN,
        SQ_ABORT
    } seq_state_t;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_SETUP,
        BUS_ACCESS
    } bus_state_t;

    typedef enum logic [1:0] {
        FAIL_NONE    = 2'd0,
        FAIL_SLAVE   = 2'd1,
        FAIL_TIMEOUT = 2'd2
    } fail_cause_t;

    typedef struct packed {
        logic  write;
        addr_t addr;
        data_t wdata;
    } bus_req_t;

    typedef struct packed {
        logic  done;
        logic  slverr;
        data_t rdata;
    } bus_rsp_t;

    function automatic data_t single_bit_word(int unsigned pos);
        data_t w;
        w = '0;
        w[pos] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/trace_seq_apb_master.sv
module trace_seq_apb_master
    import trace_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  bus_req_t req,
    output bus_rsp_t rsp,
    output logic     psel,
    output logic     penable,
    output logic     pwrite,
    output addr_t    paddr,
    output data_t    pwdata,
    input  data_t    prdata,
    input  logic     pready,
    input  logic     pslverr
);

    bus_state_t state;
    bus_req_t   held;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BUS_IDLE;
            held  <= '0;
        end else begin
            case (state)
                BUS_IDLE: begin
                    if (req_valid) begin
                        held  <= req;
                        state <= BUS_SETUP;
                    end
                end
                BUS_SETUP:  state <= BUS_ACCESS;
                BUS_ACCESS: if (pready) state <= BUS_IDLE;
                default:    state <= BUS_IDLE;
            endcase
        end
    end

    assign psel    = (state != BUS_IDLE);
    assign penable = (state == BUS_ACCESS);
    assign pwrite  = held.write;
    assign paddr   = held.addr;
    assign pwdata  = held.wdata;

    assign rsp.done   = (state == BUS_ACCESS) && pready;
    assign rsp.slverr = pslverr;
    assign rsp.rdata  = prdata;

endmodule

// File: rtl/trace_seq_ctrl.sv
module trace_seq_ctrl
    import trace_seq_pkg::*;
#(
    parameter int unsigned ENTRIES   = 16,
    parameter addr_t       EN_ADDR   = 12'h004,
    parameter addr_t       STAT_ADDR = 12'h00C,
    parameter int unsigned EN_BIT    = 0,
    parameter int unsigned IDLE_BIT  = 1,
    parameter int unsigned MAX_POLLS = 16,
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int POLL_W = $clog2(MAX_POLLS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [CNT_W-1:0]          cfg_count,
    input  logic [ENTRIES*ADDR_W-1:0] cfg_addr,
    input  logic [ENTRIES*DATA_W-1:0] cfg_data,
    input  bus_rsp_t                  rsp,
    output logic                      req_valid,
    output bus_req_t                  req,
    output logic                      busy,
    output logic                      done,
    output logic                      fail,
    output fail_cause_t               cause
);

    localparam data_t IDLE_MASK = single_bit_word(IDLE_BIT);
    localparam data_t EN_WORD   = single_bit_word(EN_BIT);

    addr_t tbl_addr [ENTRIES];
    data_t tbl_data [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
        assign tbl_addr[g] = cfg_addr[g*ADDR_W +: ADDR_W];
        assign tbl_data[g] = cfg_data[g*DATA_W +: DATA_W];
    end

    seq_state_t        state;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  n_cfg;
    logic [POLL_W-1:0] polls;
    logic              idle_seen;
    logic              poll_limit;
    logic              last_entry;

    assign idle_seen  = |(rsp.rdata & IDLE_MASK);
    assign poll_limit = (polls == POLL_W'(MAX_POLLS - 1));
    assign last_entry = ((CNT_W'(idx) + CNT_W'(1)) == n_cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_REST;
            idx   <= '0;
            n_cfg <= '0;
            polls <= '0;
            done  <= 1'b0;
            fail  <= 1'b0;
            cause <= FAIL_NONE;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            if (state == SQ_REST) begin
                if (start) begin
                    state <= SQ_DISABLE;
                    cause <= FAIL_NONE;
                    n_cfg <= (cfg_count > CNT_W'(ENTRIES)) ? CNT_W'(ENTRIES) : cfg_count;
                end
            end else if (rsp.done) begin
                if (rsp.slverr) begin
                    state <= SQ_REST;
                    fail  <= 1'b1;
                    cause <= FAIL_SLAVE;
                end else begin
                    case (state)
                        SQ_DISABLE: begin
                            state <= SQ_WAIT_IDLE;
                            polls <= '0;
                        end
                        SQ_WAIT_IDLE: begin
                            if (idle_seen) begin
                                state <= (n_cfg == '0) ? SQ_ENABLE : SQ_PROGRAM;
                                idx   <= '0;
                            end else if (poll_limit) begin
                                state <= SQ_REST;
                                fail  <= 1'b1;
                                cause <= FAIL_TIMEOUT;
                            end else begin
                                polls <= polls + POLL_W'(1);
                            end
                        end
                        SQ_PROGRAM: begin
                            if (last_entry) state <= SQ_ENABLE;
                            else            idx   <= idx + IDX_W'(1);
                        end
                        SQ_ENABLE: begin
                            state <= SQ_WAIT_RUN;
                            polls <= '0;
                        end
                        SQ_WAIT_RUN: begin
                            if (!idle_seen) begin
                                state <= SQ_REST;
                                done  <= 1'b1;
                            end else if (poll_limit) begin
                                state <= SQ_ABORT;
                            end else begin
                                polls <= polls + POLL_W'(1);
                            end
                        end
                        SQ_ABORT: begin
                            state <= SQ_REST;
                            fail  <= 1'b1;
                            cause <= FAIL_TIMEOUT;
                        end
                        default: state <= SQ_REST;
                    endcase
                end
            end
        end
    end

    always_comb begin
        req_valid = (state != SQ_REST);
        req.write = 1'b0;
        req.addr  = STAT_ADDR;
        req.wdata = '0;
        case (state)
            SQ_DISABLE, SQ_ABORT: begin
                req.write = 1'b1;
                req.addr  = EN_ADDR;
            end
            SQ_ENABLE: begin
                req.write = 1'b1;
                req.addr  = EN_ADDR;
                req.wdata = EN_WORD;
            end
            SQ_PROGRAM: begin
                req.write = 1'b1;
                req.addr  = tbl_addr[idx];
                req.wdata = tbl_data[idx];
            end
            default: ;
        endcase
    end

    assign busy = (state != SQ_REST);

endmodule

// File: rtl/trace_seq_top.sv
module trace_seq_top
    import trace_seq_pkg::*;
#(
    parameter int unsigned ENTRIES   = 16,
    parameter addr_t       EN_ADDR   = 12'h004,
    parameter addr_t       STAT_ADDR = 12'h00C,
    parameter int unsigned EN_BIT    = 0,
    parameter int unsigned IDLE_BIT  = 1,
    parameter int unsigned MAX_POLLS = 16,
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [CNT_W-1:0]          cfg_count,
    input  logic [ENTRIES*ADDR_W-1:0] cfg_addr,
    input  logic [ENTRIES*DATA_W-1:0] cfg_data,
    output logic                      busy,
    output logic                      done,
    output logic                      fail,
    output logic [1:0]                fail_cause,
    output logic                      psel,
    output logic                      penable,
    output logic                      pwrite,
    output logic [ADDR_W-1:0]         paddr,
    output logic [DATA_W-1:0]         pwdata,
    input  logic [DATA_W-1:0]         prdata,
    input  logic                      pready,
    input  logic                      pslverr
);

    bus_req_t    req;
    bus_rsp_t    rsp;
    logic        req_valid;
    fail_cause_t cause;

    trace_seq_ctrl #(
        .ENTRIES  (ENTRIES),
        .EN_ADDR  (EN_ADDR),
        .STAT_ADDR(STAT_ADDR),
        .EN_BIT   (EN_BIT),
        .IDLE_BIT (IDLE_BIT),
        .MAX_POLLS(MAX_POLLS)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cfg_count(cfg_count),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .rsp      (rsp),
        .req_valid(req_valid),
        .req      (req),
        .busy     (busy),
        .done     (done),
        .fail     (fail),
        .cause    (cause)
    );

    trace_seq_apb_master bus_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req      (req),
        .rsp      (rsp),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pready   (pready),
        .pslverr  (pslverr)
    );

    assign fail_cause = cause;

endmodule

// File: rtl/trace_seq_chk.sv
module trace_seq_chk
    import trace_seq_pkg::*;
#(
    parameter addr_t EN_ADDR = 12'h004
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [1:0]        fail_cause,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic              pready,
    input logic              pslverr
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!psel && !penable && !busy && !done && !fail));

    assert_first_write_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> (psel && !penable && pwrite && paddr == EN_ADDR && pwdata == '0));

    assert_access_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && !pready) |=> (psel && penable && $stable(paddr)
                                          && $stable(pwrite) && $stable(pwdata)));

    assert_setup_first_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(penable) |-> ($past(psel) && psel));

    assert_enable_needs_sel_R7: assert property (@(posedge clk) disable iff (rst)
        penable |-> psel);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_rest_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_quiet_at_rest_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !psel);

    assert_done_fail_apart_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !fail);

    assert_slverr_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (fail && fail_cause == 2'd1) |-> $past(psel && penable && pready && pslverr));

    assert_fail_cause_known_R9: assert property (@(posedge clk) disable iff (rst)
        fail |-> (fail_cause == 2'd1 || fail_cause == 2'd2));

    assert_start_taken_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

bind trace_seq_top trace_seq_chk #(.EN_ADDR(EN_ADDR)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_cause(fail_cause),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .pready    (pready),
    .pslverr   (pslverr)
);

// File: tb/trace_seq_top_tb_top.sv
module trace_seq_top_tb_top;
    import trace_seq_pkg::*;

    localparam int    CLK_PERIOD = 10;
    localparam int    ENTRIES    = 16;
    localparam int    CNT_W      = $clog2(ENTRIES + 1);
    localparam addr_t EN_A       = 12'h004;
    localparam addr_t ST_A       = 12'h00C;
    localparam int    EN_B       = 0;
    localparam int    IDLE_B     = 1;
    localparam int    MAXP       = 8;

    typedef struct {
        logic  write;
        addr_t addr;
        data_t data;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CNT_W-1:0]          cfg_count = '0;
    logic [ENTRIES*ADDR_W-1:0] cfg_addr;
    logic [ENTRIES*DATA_W-1:0] cfg_data;
    logic busy, done, fail;
    logic [1:0] fail_cause;
    logic psel, penable, pwrite, pready, pslverr;
    addr_t paddr;
    data_t pwdata, prdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_seq_top #(
        .ENTRIES(ENTRIES), .EN_ADDR(EN_A), .STAT_ADDR(ST_A),
        .EN_BIT(EN_B), .IDLE_BIT(IDLE_B), .MAX_POLLS(MAXP)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .cfg_count(cfg_count),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .busy(busy), .done(done),
        .fail(fail), .fail_cause(fail_cause), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr)
    );

    // ---------------- behavioural trace unit ----------------
    // mode 0 normal, 1 never reports idle, 2 never leaves idle once enabled, 3 error on err_addr
    int    lag_cfg = 0;
    int    wait_cfg = 0;
    int    mode_cfg = 0;
    addr_t err_addr = '0;
    int    token = 0;
    int    seen_token = 0;
    logic  en_reg = 1'b1;
    logic  shown = 1'b0;
    int    lag_left = 0;
    int    wait_cnt = 0;
    logic  stuck, status_idle;

    assign stuck       = (mode_cfg == 1) || (mode_cfg == 2 && en_reg);
    assign status_idle = (lag_left == 0 && !stuck) ? !en_reg : shown;
    assign pready      = psel && penable && (wait_cnt == wait_cfg);
    assign pslverr     = pready && (mode_cfg == 3) && (paddr == err_addr);
    assign prdata      = status_idle ? single_bit_word(IDLE_B) : ~single_bit_word(IDLE_B);

    always @(posedge clk) begin
        if (token != seen_token) begin
            seen_token <= token;
            en_reg     <= 1'b1;
            shown      <= 1'b0;
            lag_left   <= 0;
            wait_cnt   <= 0;
        end else if (psel && penable) begin
            if (!pready) wait_cnt <= wait_cnt + 1;
            else begin
                wait_cnt <= 0;
                if (pwrite && paddr == EN_A && !pslverr) begin
                    en_reg   <= pwdata[EN_B];
                    lag_left <= lag_cfg;
                end
                if (!pwrite && paddr == ST_A) begin
                    if (lag_left > 0) lag_left <= lag_left - 1;
                    else if (!stuck) shown <= !en_reg;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    item_t exp_q[$];
    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    int done_cnt = 0, fail_cnt = 0;
    logic [1:0] last_cause = 2'd0;
    string cur_req = "R4";

    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_cnt <= done_cnt + 1;
            if (fail) begin
                fail_cnt   <= fail_cnt + 1;
                last_cause <= fail_cause;
            end
            if (psel && penable && pready) begin
                item_t e;
                mon_checks <= mon_checks + 1;
                if (exp_q.size() == 0) begin
                    mon_errors <= mon_errors + 1;
                    $display("FAIL %s: unexpected transfer w=%0b addr=%h data=%h, expected none",
                             cur_req, pwrite, paddr, pwdata);
                end else begin
                    e = exp_q.pop_front();
                    if (e.write != pwrite || e.addr != paddr || (e.write && e.data != pwdata)) begin
                        mon_errors <= mon_errors + 1;
                        $display("FAIL %s: transfer w=%0b addr=%h data=%h, expected w=%0b addr=%h data=%h",
                                 cur_req, pwrite, paddr, pwdata, e.write, e.addr, e.data);
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic ok, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic w, input addr_t a, input data_t d);
        item_t it;
        it.write = w; it.addr = a; it.data = d;
        exp_q.push_back(it);
    endtask

    function automatic addr_t tbl_a(int i);
        return addr_t'(12'h100 + 4 * i);
    endfunction

    function automatic data_t tbl_d(int i);
        return 32'hA5C3_0000 ^ (data_t'(i) * 32'h0101_0101);
    endfunction

    // outcome: 0 done, 1 slave error, 2 timeout
    task automatic run_case(input string req, input int count, input int lag, input int waits,
                            input int mode, input int err_idx, input int outcome,
                            input bit extra_start);
        int eff, d0, f0, cyc;
        eff = (count > ENTRIES) ? ENTRIES : count;
        cur_req = req;
        push(1'b1, EN_A, '0);                                    // R2
        if (mode == 1) begin
            for (int i = 0; i < MAXP; i++) push(1'b0, ST_A, '0);  // R9
        end else begin
            for (int i = 0; i <= lag; i++) push(1'b0, ST_A, '0);  // R3
            for (int i = 0; i < eff; i++) begin                    // R4
                push(1'b1, tbl_a(i), tbl_d(i));
                if (mode == 3 && i == err_idx) break;
            end
            if (mode != 3) begin
                push(1'b1, EN_A, single_bit_word(EN_B));          // R5
                if (mode == 2) begin
                    for (int i = 0; i < MAXP; i++) push(1'b0, ST_A, '0);
                    push(1'b1, EN_A, '0);                          // R9 abort write
                end else begin
                    for (int i = 0; i <= lag; i++) push(1'b0, ST_A, '0); // R6
                end
            end
        end
        lag_cfg = lag; wait_cfg = waits; mode_cfg = mode; err_addr = tbl_a(err_idx);
        token++;
        @(negedge clk);
        d0 = done_cnt; f0 = fail_cnt;
        start = 1'b1; cfg_count = CNT_W'(count);
        @(negedge clk);
        start = 1'b0;
        check("R10", busy == 1'b1, "busy after start", int'(busy), 1);
        if (extra_start) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk); start = 1'b1;
                @(negedge clk); start = 1'b0;
                check("R10", busy == 1'b1, "busy during run", int'(busy), 1);
            end
        end
        cyc = 0;
        while (done_cnt == d0 && fail_cnt == f0 && cyc < 4000) begin
            @(negedge clk); cyc++;
        end
        repeat (12) @(negedge clk);
        check(req, exp_q.size() == 0, "transfers left unseen", exp_q.size(), 0);
        exp_q.delete();
        check(outcome == 0 ? "R6" : (outcome == 1 ? "R8" : "R9"),
              (done_cnt - d0) == (outcome == 0 ? 1 : 0), "done pulses",
              done_cnt - d0, outcome == 0 ? 1 : 0);
        check(outcome == 1 ? "R8" : "R9", (fail_cnt - f0) == (outcome == 0 ? 0 : 1),
              "fail pulses", fail_cnt - f0, outcome == 0 ? 0 : 1);
        if (outcome != 0)
            check(outcome == 1 ? "R8" : "R9", int'(last_cause) == outcome, "fail cause",
                  int'(last_cause), outcome);
        check("R6", busy == 1'b0 && psel == 1'b0, "rest after finish", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            cfg_addr[i*ADDR_W +: ADDR_W] = tbl_a(i);
            cfg_data[i*DATA_W +: DATA_W] = tbl_d(i);
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", psel == 1'b0 && penable == 1'b0, "bus quiet in reset", int'(psel), 0);
        check("R1", busy == 1'b0 && done == 1'b0 && fail == 1'b0, "status in reset",
              int'(busy), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_case("R4", 3, 2, 0, 0, 0, 0, 1'b0);   // short table, status lag
        run_case("R7", 16, 0, 2, 0, 0, 0, 1'b0);  // full table, wait states
        run_case("R4", 0, 1, 1, 0, 0, 0, 1'b0);   // empty table
        run_case("R4", 20, 0, 0, 0, 0, 0, 1'b0);  // count limited to depth
        run_case("R9", 4, 0, 0, 1, 0, 2, 1'b0);   // never idle: early timeout
        run_case("R9", 2, 1, 1, 2, 0, 2, 1'b0);   // never runs: late timeout + disable
        run_case("R8", 5, 1, 0, 3, 2, 1, 1'b0);   // slave error on entry 2
        run_case("R10", 4, 3, 1, 0, 0, 0, 1'b1);  // starts while busy ignored

        checks += mon_checks;
        errors += mon_errors;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors + mon_errors + 1,
                 checks + mon_checks + 1);
        $finish;
    end

endmodule